// File: doc/BRIEF.md
# Memory-Mapped TLB Address Array Write Port

This block holds the address half of a 64-entry unified translation buffer and a 4-entry instruction translation buffer. Each unified entry carries a 22-bit virtual page number, an 8-bit address space identifier, a dirty flag and a valid flag. Software changes the array through one memory-mapped write port. A single address bit chooses how the write is applied. An indexed write replaces one entry, picked by address bits. An associative write searches every unified entry for the given page and space identifier, then updates only the flags of each hit. The result is also carried into the instruction buffer.

The associative search is sequential and visits one unified entry per clock. While it runs, `busy` is high and further writes are dropped. Two conditions are reported. A second hit in one search raises a multiple-hit exception, which carries a fixed code and latches the faulting write address. When a valid translation disappears, a one-cycle page-flush request is issued. The block also holds a replacement counter and its wrap boundary in a control word. The counter advances on each indexed write and on each unified entry that a search visits. Two view ports let the neighbouring lookup and readback logic see any entry.

Top module: `tlb_addr_array`

## Requirements
- R1: Write data is decoded as page number in bits 31:10, dirty in bit 9, valid in bit 8 and space identifier in bits 7:0; `u_ent`/`i_ent` present entries in the same layout. A write with `wr_addr[7]`=0 is indexed: it replaces all four fields of unified entry `wr_addr[13:8]` in one cycle, and `busy` stays low.
- R2: An indexed write over a valid entry raises `flush_req` for one cycle, in the cycle after the write, with `flush_addr` = old page number shifted left by 10. No request is raised if the old entry was invalid, or if an instruction entry is identical to it in all four fields.
- R3: A write with `wr_addr[7]`=1 is associative. Only unified entries that are valid and match in both page number and space identifier are updated, and only their dirty and valid flags change. Entries that are invalid or do not match keep their contents.
- R4: If a second valid unified entry matches during one search, `exc_pulse` is high for one cycle and `exc_code` reads 0x140. `exc_addr` holds the full write address. The search stops there: the second hit and every later entry are left unchanged.
- R5: After the unified search, the lowest-numbered instruction entry whose page number and space identifier match is updated. Its valid flag is ignored in the comparison. If any unified entry was hit, that instruction entry receives the written dirty and valid flags. Otherwise only its valid flag is written. Other instruction entries are unchanged.
- R6: An associative write raises `flush_req` once, in the cycle after the search ends, with `flush_addr` = written page number shifted left by 10, if any hit entry (unified or instruction) went from valid to invalid. Otherwise it raises none.
- R7: On each increment the replacement counter becomes count+1, except that it wraps to 0 when count+1 equals the boundary or equals 63.
- R8: The counter increments once per indexed write. During a search it increments once for each unified entry examined, except the entry at which a multiple hit stops the search.
- R9: From the cycle after an associative write is accepted, `busy` stays high for 65 cycles on a full search. Writes presented while `busy` is high are ignored.
- R10: After reset all valid flags are clear, the counter and boundary are 0, and `busy`, `flush_req` and `exc_pulse` are low.
- R11: `ctl_we` loads the boundary from `ctl_bound_in` and the counter from `ctl_count_in`. `ctl_q` shows the boundary in bits 23:18 and the counter in bits 15:10, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Memory-mapped write strobe |
| wr_addr | input | 32 | Write address (bit 7 mode, bits 13:8 entry) |
| wr_data | input | 32 | Write data (entry layout) |
| busy | output | 1 | Associative search in progress |
| ctl_we | input | 1 | Control word load strobe |
| ctl_bound_in | input | 6 | Boundary value to load |
| ctl_count_in | input | 6 | Counter value to load |
| ctl_q | output | 32 | Control word |
| it_ld_en | input | 1 | Instruction entry load strobe |
| it_ld_idx | input | 2 | Instruction entry to load |
| it_ld_data | input | 32 | Instruction entry contents |
| u_sel | input | 6 | Unified entry to view |
| u_ent | output | 32 | Viewed unified entry |
| i_sel | input | 2 | Instruction entry to view |
| i_ent | output | 32 | Viewed instruction entry |
| flush_req | output | 1 | One-cycle page flush request |
| flush_addr | output | 32 | Page address to flush |
| exc_pulse | output | 1 | One-cycle multiple-hit exception |
| exc_code | output | 12 | Exception code |
| exc_addr | output | 32 | Captured faulting write address |

## Verification
The bench builds the block with its default sizes: 64 unified entries and 4 instruction entries. At 64 entries, a full search takes 65 busy cycles and makes 64 counter steps. That path reaches the wrap at 63 with the boundary at 0, which can then be checked against an exact end value. Four instruction entries leave room to place two identical matches, which shows that only the lowest-numbered one is updated. The multiple-hit case uses hits at entries 30 and 31. The counter reads 31 afterwards, which shows where the search stopped.

// File: rtl/tlbaa_pkg.sv
package tlbaa_pkg;
  localparam int VPN_W      = 22;
  localparam int ASID_W     = 8;
  localparam int PAGE_SHIFT = 10;
  localparam int MODE_BIT   = 7;
  localparam int IDX_LSB    = 8;
  localparam int CNT_LSB    = 10;
  localparam int BND_LSB    = 18;
  localparam logic [11:0] EXC_MULTI = 12'h140;

  // Entry layout matches the write-data word.
  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic              dirty;
    logic              valid;
    logic [ASID_W-1:0] asid;
  } tlb_ent_t;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_IUPD} scan_st_e;
endpackage

// File: rtl/tlbaa_repl_ctr.sv
module tlbaa_repl_ctr #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_count,
  input  logic [W-1:0] ld_bound,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic [W-1:0] bound
);
  localparam logic [W-1:0] WRAP = W'(N - 1);

  logic [W-1:0] count_d, bound_d, step;

  always_comb begin
    count_d = count;
    bound_d = bound;
    step    = count + W'(1);
    if (ld_en) begin
      count_d = ld_count;
      bound_d = ld_bound;
    end else if (inc) begin
      count_d = ((step == bound) || (step == WRAP)) ? '0 : step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      bound <= '0;
    end else if (ld_en || inc) begin
      count <= count_d;
      bound <= bound_d;
    end
  end

  // R7
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_en) |=> (count != WRAP));
endmodule

// File: rtl/tlbaa_itlb.sv
module tlbaa_itlb
  import tlbaa_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  tlb_ent_t          ld_ent,
  input  logic              upd_en,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              full_copy,
  input  logic              new_dirty,
  input  logic              new_valid,
  input  tlb_ent_t          cmp_ent,
  output logic              same_found,
  output logic              drop,
  input  logic [IW-1:0]     sel,
  output tlb_ent_t          sel_ent
);
  tlb_ent_t      ent_q [N];
  tlb_ent_t      ent_d [N];
  logic          hit;
  logic [IW-1:0] fidx;

  // Lowest-numbered entry whose page and space identifier match wins.
  always_comb begin
    hit  = 1'b0;
    fidx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ent_q[i].vpn == key_vpn && ent_q[i].asid == key_asid) begin
        hit  = 1'b1;
        fidx = IW'(i);
      end
    end
  end

  always_comb begin
    same_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ent_q[i] == cmp_ent) same_found = 1'b1;
    end
  end

  assign drop    = upd_en && hit && ent_q[fidx].valid && !new_valid;
  assign sel_ent = ent_q[sel];

  always_comb begin
    for (int i = 0; i < N; i++) ent_d[i] = ent_q[i];
    if (upd_en) begin
      if (hit) begin
        ent_d[fidx].valid = new_valid;
        if (full_copy) ent_d[fidx].dirty = new_dirty;
      end
    end else if (ld_en) begin
      ent_d[ld_idx] = ld_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (upd_en || ld_en) begin
      for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
    end
  end

  // R5
  it_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && hit && !new_valid) |=> !ent_q[$past(fidx)].valid);
endmodule

// File: rtl/tlb_addr_array.sv
module tlb_addr_array
  import tlbaa_pkg::*;
#(
  parameter int UTLB_N = 64,
  parameter int ITLB_N = 4,
  localparam int IDX_W = $clog2(UTLB_N),
  localparam int IT_W  = (ITLB_N > 1) ? $clog2(ITLB_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_addr,
  input  logic [31:0]       wr_data,
  output logic              busy,
  input  logic              ctl_we,
  input  logic [IDX_W-1:0]  ctl_bound_in,
  input  logic [IDX_W-1:0]  ctl_count_in,
  output logic [31:0]       ctl_q,
  input  logic              it_ld_en,
  input  logic [IT_W-1:0]   it_ld_idx,
  input  logic [31:0]       it_ld_data,
  input  logic [IDX_W-1:0]  u_sel,
  output logic [31:0]       u_ent,
  input  logic [IT_W-1:0]   i_sel,
  output logic [31:0]       i_ent,
  output logic              flush_req,
  output logic [31:0]       flush_addr,
  output logic              exc_pulse,
  output logic [11:0]       exc_code,
  output logic [31:0]       exc_addr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(UTLB_N - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  tlb_ent_t   utlb [UTLB_N];
  scan_st_e   st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  tlb_ent_t   req_q, req_d;
  logic [31:0] addr_q, addr_d;
  logic       hit_q, hit_d, fpend_q, fpend_d;
  logic       flush_d, exc_d;
  logic [31:0] faddr_d, tea_d;
  logic [11:0] ecode_d;

  logic             u_we;
  logic [IDX_W-1:0] u_widx;
  tlb_ent_t         u_wdata;
  logic             cnt_inc, it_upd, it_same, it_drop;
  logic [IDX_W-1:0] cnt, bnd;
  tlb_ent_t         old_ent, cur_ent, isel_ent;
  logic [IDX_W-1:0] wr_idx;
  logic             cur_match, idx_acc;

  assign wr_idx    = wr_addr[IDX_LSB +: IDX_W];
  assign old_ent   = utlb[wr_idx];
  assign cur_ent   = utlb[ptr_q];
  assign cur_match = cur_ent.valid && (cur_ent.vpn == req_q.vpn) &&
                     (cur_ent.asid == req_q.asid);
  assign idx_acc   = wr_en && (st_q == S_IDLE) && !wr_addr[MODE_BIT];
  assign busy      = (st_q != S_IDLE);
  assign u_ent     = utlb[u_sel];
  assign i_ent     = isel_ent;
  assign ctl_q     = (32'(bnd) << BND_LSB) | (32'(cnt) << CNT_LSB);

  tlbaa_repl_ctr #(.N(UTLB_N)) ctr_i (
    .clk      (clk),
    .rst_n    (rst_ok),
    .ld_en    (ctl_we),
    .ld_count (ctl_count_in),
    .ld_bound (ctl_bound_in),
    .inc      (cnt_inc),
    .count    (cnt),
    .bound    (bnd)
  );

  tlbaa_itlb #(.N(ITLB_N)) itlb_i (
    .clk       (clk),
    .rst_n     (rst_ok),
    .ld_en     (it_ld_en),
    .ld_idx    (it_ld_idx),
    .ld_ent    (tlb_ent_t'(it_ld_data)),
    .upd_en    (it_upd),
    .key_vpn   (req_q.vpn),
    .key_asid  (req_q.asid),
    .full_copy (hit_q),
    .new_dirty (req_q.dirty),
    .new_valid (req_q.valid),
    .cmp_ent   (old_ent),
    .same_found(it_same),
    .drop      (it_drop),
    .sel       (i_sel),
    .sel_ent   (isel_ent)
  );

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    req_d   = req_q;
    addr_d  = addr_q;
    hit_d   = hit_q;
    fpend_d = fpend_q;
    u_we    = 1'b0;
    u_widx  = ptr_q;
    u_wdata = cur_ent;
    cnt_inc = 1'b0;
    it_upd  = 1'b0;
    flush_d = 1'b0;
    faddr_d = flush_addr;
    exc_d   = 1'b0;
    ecode_d = exc_code;
    tea_d   = exc_addr;
    unique case (st_q)
      S_IDLE: begin
        if (wr_en) begin
          if (wr_addr[MODE_BIT]) begin
            st_d    = S_SCAN;
            ptr_d   = '0;
            req_d   = tlb_ent_t'(wr_data);
            addr_d  = wr_addr;
            hit_d   = 1'b0;
            fpend_d = 1'b0;
          end else begin
            u_we    = 1'b1;
            u_widx  = wr_idx;
            u_wdata = tlb_ent_t'(wr_data);
            cnt_inc = 1'b1;
            if (old_ent.valid && !it_same) begin
              flush_d = 1'b1;
              faddr_d = {old_ent.vpn, {PAGE_SHIFT{1'b0}}};
            end
          end
        end
      end
      S_SCAN: begin
        if (cur_match && hit_q) begin
          exc_d   = 1'b1;
          ecode_d = EXC_MULTI;
          tea_d   = addr_q;
          st_d    = S_IUPD;
        end else begin
          cnt_inc = 1'b1;
          if (cur_match) begin
            u_we          = 1'b1;
            u_wdata.dirty = req_q.dirty;
            u_wdata.valid = req_q.valid;
            hit_d         = 1'b1;
            if (!req_q.valid) fpend_d = 1'b1;
          end
          if (ptr_q == LAST) st_d = S_IUPD;
          else               ptr_d = ptr_q + IDX_W'(1);
        end
      end
      S_IUPD: begin
        it_upd = 1'b1;
        st_d   = S_IDLE;
        if (fpend_q || it_drop) begin
          flush_d = 1'b1;
          faddr_d = {req_q.vpn, {PAGE_SHIFT{1'b0}}};
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q       <= S_IDLE;
      ptr_q      <= '0;
      req_q      <= '0;
      addr_q     <= '0;
      hit_q      <= 1'b0;
      fpend_q    <= 1'b0;
      flush_req  <= 1'b0;
      flush_addr <= '0;
      exc_pulse  <= 1'b0;
      exc_code   <= '0;
      exc_addr   <= '0;
    end else begin
      st_q       <= st_d;
      ptr_q      <= ptr_d;
      req_q      <= req_d;
      addr_q     <= addr_d;
      hit_q      <= hit_d;
      fpend_q    <= fpend_d;
      flush_req  <= flush_d;
      flush_addr <= faddr_d;
      exc_pulse  <= exc_d;
      exc_code   <= ecode_d;
      exc_addr   <= tea_d;
    end
  end

  for (genvar g = 0; g < UTLB_N; g++) begin : g_utlb
    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) begin
        utlb[g] <= '0;
      end else if (u_we && (u_widx == IDX_W'(g))) begin
        utlb[g] <= u_wdata;
      end
    end
  end

  // R9
  assoc_busy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && !busy && wr_addr[MODE_BIT]) |=> busy);

  // R1
  idx_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && !busy && !wr_addr[MODE_BIT]) |=> !busy);

  // R4
  exc_stop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    exc_pulse |=> !busy);

  // R4
  exc_code_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    exc_pulse |-> (exc_code == EXC_MULTI));

  // R6
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    flush_req |-> ($past(st_q) == S_IUPD || $past(idx_acc)));
endmodule

// File: tb/tlb_addr_array_tb_top.sv
module tlb_addr_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        busy;
  logic        ctl_we = 1'b0;
  logic [5:0]  ctl_bound_in = '0;
  logic [5:0]  ctl_count_in = '0;
  logic [31:0] ctl_q;
  logic        it_ld_en = 1'b0;
  logic [1:0]  it_ld_idx = '0;
  logic [31:0] it_ld_data = '0;
  logic [5:0]  u_sel = '0;
  logic [31:0] u_ent;
  logic [1:0]  i_sel = '0;
  logic [31:0] i_ent;
  logic        flush_req;
  logic [31:0] flush_addr;
  logic        exc_pulse;
  logic [11:0] exc_code;
  logic [31:0] exc_addr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  tlb_addr_array dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .ctl_we(ctl_we),
    .ctl_bound_in(ctl_bound_in), .ctl_count_in(ctl_count_in), .ctl_q(ctl_q),
    .it_ld_en(it_ld_en), .it_ld_idx(it_ld_idx), .it_ld_data(it_ld_data),
    .u_sel(u_sel), .u_ent(u_ent), .i_sel(i_sel), .i_ent(i_ent),
    .flush_req(flush_req), .flush_addr(flush_addr), .exc_pulse(exc_pulse),
    .exc_code(exc_code), .exc_addr(exc_addr)
  );

  localparam logic [31:0] BASE = 32'hF600_0000;
  localparam logic [21:0] PA   = 22'h2ABCD;
  localparam logic [21:0] PB   = 22'h0BEEF;

  function automatic logic [31:0] mk(logic [21:0] v, logic d, logic ok, logic [7:0] a);
    return {v, d, ok, a};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idx_wr(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = BASE | (32'(idx) << 8); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl_ld(logic [5:0] b, logic [5:0] c);
    @(negedge clk);
    ctl_we = 1'b1; ctl_bound_in = b; ctl_count_in = c;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic it_ld(int idx, logic [31:0] d);
    @(negedge clk);
    it_ld_en = 1'b1; it_ld_idx = 2'(idx); it_ld_data = d;
    @(negedge clk);
    it_ld_en = 1'b0;
  endtask

  task automatic peek_u(int idx, output logic [31:0] v);
    u_sel = 6'(idx); #0.1; v = u_ent;
  endtask

  task automatic peek_i(int idx, output logic [31:0] v);
    i_sel = 2'(idx); #0.1; v = i_ent;
  endtask

  task automatic run_assoc(logic [31:0] a, logic [31:0] d, bit poke,
                           output int cyc, output bit sx, output bit sf,
                           output logic [31:0] fa);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    if (poke) begin
      wr_addr = BASE | (32'd20 << 8); wr_data = mk(22'h01234, 1'b1, 1'b1, 8'h99);
    end else wr_en = 1'b0;
    cyc = 0; sx = 1'b0;
    while (busy && cyc < 300) begin
      cyc++;
      sx |= exc_pulse;
      @(negedge clk);
      wr_en = 1'b0;
    end
    sx |= exc_pulse;
    sf = flush_req;
    fa = flush_addr;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 ctl", ctl_q, 32'h0);
    chk("R10 busy", 32'(busy), 32'h0);
    chk("R10 flush", 32'(flush_req), 32'h0);
    chk("R10 exc", 32'(exc_pulse), 32'h0);
    peek_u(0, v);  chk("R10 valid e0", 32'(v[8]), 32'h0);
    peek_u(63, v); chk("R10 valid e63", 32'(v[8]), 32'h0);
    peek_i(3, v);  chk("R10 itlb valid", 32'(v[8]), 32'h0);
  endtask

  task automatic t_ctl();
    ctl_ld(6'd3, 6'd5);
    chk("R11 ctl fields", ctl_q, 32'h000C_1400);
  endtask

  task automatic t_indexed();
    logic [31:0] v;
    ctl_ld(6'd0, 6'd0);
    idx_wr(5, mk(22'h12345, 1'b1, 1'b1, 8'hA7));
    chk("R2 no flush on invalid old", 32'(flush_req), 32'h0);
    chk("R1 busy low", 32'(busy), 32'h0);
    peek_u(5, v); chk("R1 entry fields", v, mk(22'h12345, 1'b1, 1'b1, 8'hA7));
    chk("R8 one step per indexed write", ctl_q, 32'h0000_0400);
    idx_wr(5, mk(22'h00111, 1'b0, 1'b1, 8'h01));
    chk("R2 flush raised", 32'(flush_req), 32'h1);
    chk("R2 flush addr", flush_addr, {22'h12345, 10'b0});
    @(negedge clk);
    chk("R2 flush one cycle", 32'(flush_req), 32'h0);
    it_ld(2, mk(22'h00111, 1'b0, 1'b1, 8'h01));
    idx_wr(5, mk(22'h00222, 1'b0, 1'b0, 8'h02));
    chk("R2 no flush when itlb identical", 32'(flush_req), 32'h0);
    peek_u(5, v); chk("R1 overwrite", v, mk(22'h00222, 1'b0, 1'b0, 8'h02));
  endtask

  task automatic t_assoc_update();
    logic [31:0] v, fa;
    int cyc; bit sx, sf;
    for (int i = 0; i < 4; i++) it_ld(i, mk(22'h3FFF00 + 22'(i), 1'b0, 1'b0, 8'hEE));
    idx_wr(10, mk(PA, 1'b0, 1'b1, 8'h33));
    idx_wr(11, mk(PA, 1'b0, 1'b1, 8'h44));
    idx_wr(12, mk(PA, 1'b0, 1'b0, 8'h33));
    ctl_ld(6'd0, 6'd0);
    run_assoc(BASE | 32'h80, mk(PA, 1'b1, 1'b1, 8'h33), 1'b1, cyc, sx, sf, fa);
    chk("R9 busy length", 32'(cyc), 32'd65);
    peek_u(20, v); chk("R9 write during busy ignored", v, 32'h0);
    peek_u(10, v); chk("R3 hit flags updated", v, mk(PA, 1'b1, 1'b1, 8'h33));
    peek_u(11, v); chk("R3 other asid untouched", v, mk(PA, 1'b0, 1'b1, 8'h44));
    peek_u(12, v); chk("R3 invalid untouched", v, mk(PA, 1'b0, 1'b0, 8'h33));
    chk("R6 no flush when still valid", 32'(sf), 32'h0);
    chk("R8 R7 count after 64 steps", ctl_q, 32'h0000_0400);
    chk("R4 no exception", 32'(sx), 32'h0);
  endtask

  task automatic t_assoc_itlb();
    logic [31:0] v, fa;
    int cyc; bit sx, sf;
    it_ld(1, mk(PA, 1'b1, 1'b1, 8'h33));
    it_ld(3, mk(PA, 1'b1, 1'b1, 8'h33));
    run_assoc(BASE | 32'h80, mk(PA, 1'b0, 1'b0, 8'h33), 1'b0, cyc, sx, sf, fa);
    chk("R6 flush on invalidation", 32'(sf), 32'h1);
    chk("R6 flush addr", fa, {PA, 10'b0});
    peek_u(10, v); chk("R3 invalidated", v, mk(PA, 1'b0, 1'b0, 8'h33));
    peek_i(1, v);  chk("R5 first itlb full copy", v, mk(PA, 1'b0, 1'b0, 8'h33));
    peek_i(3, v);  chk("R5 later itlb untouched", v, mk(PA, 1'b1, 1'b1, 8'h33));
    run_assoc(BASE | 32'h80, mk(PA, 1'b1, 1'b1, 8'h33), 1'b0, cyc, sx, sf, fa);
    peek_i(1, v);  chk("R5 only valid written", v, mk(PA, 1'b0, 1'b1, 8'h33));
    peek_u(10, v); chk("R3 invalid not revived", v, mk(PA, 1'b0, 1'b0, 8'h33));
    chk("R6 no flush without drop", 32'(sf), 32'h0);
  endtask

  task automatic t_multi();
    logic [31:0] v, fa;
    int cyc; bit sx, sf;
    idx_wr(30, mk(PB, 1'b0, 1'b1, 8'h55));
    idx_wr(31, mk(PB, 1'b0, 1'b1, 8'h55));
    idx_wr(40, mk(PB, 1'b0, 1'b1, 8'h55));
    ctl_ld(6'd0, 6'd0);
    run_assoc(32'hF600_1A80, mk(PB, 1'b1, 1'b1, 8'h55), 1'b0, cyc, sx, sf, fa);
    chk("R4 exception pulse", 32'(sx), 32'h1);
    chk("R4 exception code", 32'(exc_code), 32'h140);
    chk("R4 exception addr", exc_addr, 32'hF600_1A80);
    peek_u(30, v); chk("R4 first hit updated", v, mk(PB, 1'b1, 1'b1, 8'h55));
    peek_u(31, v); chk("R4 second hit untouched", v, mk(PB, 1'b0, 1'b1, 8'h55));
    peek_u(40, v); chk("R4 scan stopped", v, mk(PB, 1'b0, 1'b1, 8'h55));
    chk("R8 count stops at multi hit", ctl_q, 32'h0000_7C00);
  endtask

  task automatic t_wrap();
    ctl_ld(6'd5, 6'd3);
    idx_wr(50, mk(22'h1, 1'b0, 1'b0, 8'h0));
    chk("R7 plain step", ctl_q, 32'h0014_1000);
    idx_wr(51, mk(22'h2, 1'b0, 1'b0, 8'h0));
    chk("R7 wrap at boundary", ctl_q, 32'h0014_0000);
    ctl_ld(6'd0, 6'd62);
    idx_wr(52, mk(22'h3, 1'b0, 1'b0, 8'h0));
    chk("R7 wrap at 63", ctl_q, 32'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctl();
    t_indexed();
    t_assoc_update();
    t_assoc_itlb();
    t_multi();
    t_wrap();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule